// File: doc/BRIEF.md
# Mode-Selected 32-bit Integer ALU

A purely combinational integer arithmetic-logic unit for a 32-bit datapath. Two operands and a 4-bit mode code enter; a 32-bit result, a carry flag and a signed-overflow flag leave in the same cycle. The unit covers addition and subtraction, each in a trapping (signed) flavour that reports overflow and a non-trapping (unsigned) flavour that never does. It also covers the four bitwise operations AND, OR, XOR and NOR, and a signed and an unsigned compare that return 1 or 0.

One adder serves every arithmetic mode. Subtraction feeds the adder the bitwise inverse of the second operand and a carry-in of 1. Signed overflow is taken from the XOR of the carries into and out of the top bit. Both compares run the adder as a subtractor: the signed compare reads the difference's sign corrected by the overflow term, and the unsigned compare reads the absence of a carry-out. The surrounding pipeline owns any trap taken on the overflow flag.

Top module: `int_alu32`

## Requirements
- R1: Modes 0x0 (trapping add) and 0x1 (non-trapping add) return `op_a + op_b` modulo 2^32, and `carry_flag` is the carry out of bit 31 of that sum.
- R2: Modes 0x2 (trapping subtract) and 0x3 (non-trapping subtract) return `op_a - op_b` modulo 2^32, computed as `op_a + ~op_b + 1`; `carry_flag` is the carry out of bit 31 of that sum, which is 1 exactly when `op_a >= op_b` as unsigned numbers.
- R3: In modes 0x0 and 0x2, `ovf_flag` is 1 exactly when the true signed result lies outside the 32-bit two's complement range (the carry into bit 31 differs from the carry out of it).
- R4: In modes 0x1 and 0x3, `ovf_flag` is always 0, whatever the operands.
- R5: A trapping add of operands with different sign bits, and a trapping subtract of operands with equal sign bits, never raise `ovf_flag`.
- R6: Modes 0x4, 0x5, 0x6 and 0x7 return the bitwise AND, OR, XOR and NOR of the operands, with both flags 0.
- R7: Mode 0xA returns 1 in bit 0 and 0 in bits 31..1 when `op_a < op_b` as signed numbers, else all zeros, and stays correct when `op_a - op_b` overflows; both flags are 0.
- R8: Mode 0xB returns 1 in bit 0 and 0 in bits 31..1 when `op_a < op_b` as unsigned numbers, else all zeros; both flags are 0.
- R9: Mode codes 0x8, 0x9, 0xC, 0xD, 0xE and 0xF return an all-zero result with both flags 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| mode | input | 4 | Operation select code |
| result | output | 32 | Operation result |
| carry_flag | output | 1 | Carry out of bit 31 in add and subtract modes, else 0 |
| ovf_flag | output | 1 | Signed overflow in trapping add and subtract modes, else 0 |

## Verification
Whenever the inputs change, the bound checker tests the parts of the behaviour that a short rule over the ports can decide. It checks that the non-trapping modes never flag overflow, and that operands whose sign bits rule out overflow never raise it. It also checks that the add result matches a plain sum, that trapping overflow agrees with the operand and result sign bits, and that compares, logic and unused codes clear both flags, with compares leaving bits 31..1 clear and unused codes leaving the result at zero. Only the bench's scenarios show the exact values. These are the carry and no-borrow flag at the unsigned boundaries, the signed compare's answer when the internal difference overflows, the NOR and XOR patterns, and agreement with an independent model across a spread of pseudo-random operands in all sixteen codes.

// File: rtl/int_alu_pkg.sv
// Package: shared width and mode code definitions for the integer ALU.
// Assumes a single 4-bit mode field; codes not listed are treated as unused.
package int_alu_pkg;

    localparam int ALU_W    = 32;
    localparam int MODE_W   = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_ADD_TRAP  = 4'h0,
        MODE_ADD_WRAP  = 4'h1,
        MODE_SUB_TRAP  = 4'h2,
        MODE_SUB_WRAP  = 4'h3,
        MODE_AND       = 4'h4,
        MODE_OR        = 4'h5,
        MODE_XOR       = 4'h6,
        MODE_NOR       = 4'h7,
        MODE_LT_SIGNED = 4'hA,
        MODE_LT_UNSIGN = 4'hB
    } alu_mode_e;

    // Result source chosen by the decoder.
    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_SUM   = 2'd1,
        SRC_LOGIC = 2'd2,
        SRC_LESS  = 2'd3
    } alu_src_e;

    // Control bundle produced by the mode decoder.
    typedef struct packed {
        logic       invert_b;    // subtract: invert op_b and force carry-in
        logic       flag_carry;  // expose adder carry-out
        logic       flag_ovf;    // expose signed overflow (trapping modes)
        logic       less_signed; // compare selects signed answer
        logic [1:0] logic_sel;   // 0 AND, 1 OR, 2 XOR, 3 NOR
        alu_src_e   src;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_mode_decode.sv
// Module: alu_mode_decode
// Turns the 4-bit mode code into the control bundle that steers the adder,
// the bitwise unit and the result select. Assumes unused codes select zero.
module alu_mode_decode
    import int_alu_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output alu_ctrl_t         ctrl
);

    // Decode every mode code into its control fields.
    always_comb begin
        ctrl             = '0;
        ctrl.src         = SRC_ZERO;
        ctrl.logic_sel   = mode[1:0];
        case (mode)
            MODE_ADD_TRAP: begin
                ctrl.src        = SRC_SUM;
                ctrl.flag_carry = 1'b1;
                ctrl.flag_ovf   = 1'b1;
            end
            MODE_ADD_WRAP: begin
                ctrl.src        = SRC_SUM;
                ctrl.flag_carry = 1'b1;
            end
            MODE_SUB_TRAP: begin
                ctrl.src        = SRC_SUM;
                ctrl.invert_b   = 1'b1;
                ctrl.flag_carry = 1'b1;
                ctrl.flag_ovf   = 1'b1;
            end
            MODE_SUB_WRAP: begin
                ctrl.src        = SRC_SUM;
                ctrl.invert_b   = 1'b1;
                ctrl.flag_carry = 1'b1;
            end
            MODE_AND, MODE_OR, MODE_XOR, MODE_NOR: begin
                ctrl.src        = SRC_LOGIC;
            end
            MODE_LT_SIGNED: begin
                ctrl.src         = SRC_LESS;
                ctrl.invert_b    = 1'b1;
                ctrl.less_signed = 1'b1;
            end
            MODE_LT_UNSIGN: begin
                ctrl.src        = SRC_LESS;
                ctrl.invert_b   = 1'b1;
            end
            default: begin
                ctrl.src        = SRC_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/alu_ripple_adder.sv
// Module: alu_ripple_adder
// W-bit adder built from per-bit full-adder cells with a rippled carry.
// Exposes the carry into and out of the most significant bit so the caller
// can form the signed overflow term. Assumes W >= 2.
module alu_ripple_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    input  logic         carry_in,
    output logic [W-1:0] sum,
    output logic         carry_into_msb,
    output logic         carry_out_msb
);

    logic [W:0] chain;

    // Seed the carry chain.
    assign chain[0] = carry_in;

    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_cell
            logic gen_k;
            logic prop_k;
            // Per-bit generate and propagate terms.
            assign gen_k        = in_x[k] & in_y[k];
            assign prop_k       = in_x[k] ^ in_y[k];
            // Sum bit and carry to the next cell.
            assign sum[k]       = prop_k ^ chain[k];
            assign chain[k+1]   = gen_k | (prop_k & chain[k]);
        end
    endgenerate

    assign carry_into_msb = chain[W-1];
    assign carry_out_msb  = chain[W];

endmodule

// File: rtl/alu_bitwise_unit.sv
// Module: alu_bitwise_unit
// Bitwise AND/OR/XOR/NOR of two W-bit operands. NOR is formed as the OR
// term XORed with all ones so it shares the OR gates.
module alu_bitwise_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    input  logic [1:0]   sel,
    output logic [W-1:0] out
);

    logic [W-1:0] or_term;

    assign or_term = in_x | in_y;

    // Pick the selected bitwise function.
    always_comb begin
        case (sel)
            2'd0:    out = in_x & in_y;
            2'd1:    out = or_term;
            2'd2:    out = in_x ^ in_y;
            default: out = or_term ^ {W{1'b1}};
        endcase
    end

endmodule

// File: rtl/int_alu32.sv
// Module: int_alu32 (top)
// Combinational 32-bit integer ALU: add/subtract in trapping and wrapping
// flavours, four bitwise functions, signed and unsigned compare. One adder
// serves every arithmetic mode; compares run it as a subtractor.
// Assumes the caller acts on ovf_flag; no state is held.
module int_alu32
    import int_alu_pkg::*;
(
    input  logic [ALU_W-1:0]  op_a,
    input  logic [ALU_W-1:0]  op_b,
    input  logic [MODE_W-1:0] mode,
    output logic [ALU_W-1:0]  result,
    output logic              carry_flag,
    output logic              ovf_flag
);

    alu_ctrl_t        ctrl;
    logic [ALU_W-1:0] y_operand;
    logic [ALU_W-1:0] sum;
    logic             c_into_msb;
    logic             c_out_msb;
    logic             ovf_raw;
    logic             less_bit;
    logic [ALU_W-1:0] logic_out;

    alu_mode_decode u_decode (
        .mode (mode),
        .ctrl (ctrl)
    );

    // Second adder operand: inverted for subtract and compare.
    assign y_operand = ctrl.invert_b ? ~op_b : op_b;

    alu_ripple_adder #(.W(ALU_W)) u_adder (
        .in_x           (op_a),
        .in_y           (y_operand),
        .carry_in       (ctrl.invert_b),
        .sum            (sum),
        .carry_into_msb (c_into_msb),
        .carry_out_msb  (c_out_msb)
    );

    alu_bitwise_unit #(.W(ALU_W)) u_logic (
        .in_x (op_a),
        .in_y (op_b),
        .sel  (ctrl.logic_sel),
        .out  (logic_out)
    );

    // Signed overflow from the two top carries.
    assign ovf_raw = c_into_msb ^ c_out_msb;

    // Compare answer: corrected sign for signed, no-borrow for unsigned.
    assign less_bit = ctrl.less_signed ? (sum[ALU_W-1] ^ ovf_raw) : ~c_out_msb;

    // Final result select.
    always_comb begin
        case (ctrl.src)
            SRC_SUM:   result = sum;
            SRC_LOGIC: result = logic_out;
            SRC_LESS:  result = {{(ALU_W-1){1'b0}}, less_bit};
            default:   result = '0;
        endcase
    end

    // Flags gated by the decoded mode.
    assign carry_flag = ctrl.flag_carry & c_out_msb;
    assign ovf_flag   = ctrl.flag_ovf & ovf_raw;

endmodule

// File: rtl/int_alu32_checker.sv
// Module: int_alu32_checker
// Port-level rules for int_alu32, checked whenever the inputs or outputs
// change. Bound to every int_alu32 instance below.
module int_alu32_checker
    import int_alu_pkg::*;
(
    input logic [ALU_W-1:0]  op_a,
    input logic [ALU_W-1:0]  op_b,
    input logic [MODE_W-1:0] mode,
    input logic [ALU_W-1:0]  result,
    input logic              carry_flag,
    input logic              ovf_flag
);

    logic is_arith;
    logic is_wrap;
    logic is_unused;
    logic [ALU_W-1:0] plain_sum;

    assign is_arith  = (mode[3:2] == 2'b00);
    assign is_wrap   = (mode == 4'h1) || (mode == 4'h3);
    assign is_unused = (mode == 4'h8) || (mode == 4'h9) || (mode[3:2] == 2'b11);
    assign plain_sum = op_a + op_b;

    // Evaluate the port rules on every change.
    always_comb begin
        // R4: wrapping add/subtract never flag overflow
        assert_no_overflow_R4: assert (!(is_wrap && ovf_flag))
            else $error("R4 overflow raised in wrapping mode %h", mode);
        // R5: opposite-sign add and same-sign subtract cannot overflow
        assert_safe_signs_R5: assert (!(((mode == 4'h0) && (op_a[31] != op_b[31]) ||
                                         (mode == 4'h2) && (op_a[31] == op_b[31])) && ovf_flag))
            else $error("R5 impossible overflow");
        // R1: add result equals the plain sum
        assert_add_sum_R1: assert (!((mode == 4'h0) || (mode == 4'h1)) || (result == plain_sum))
            else $error("R1 add result mismatch");
        // R3: trapping add overflow matches operand/result signs
        assert_add_ovf_R3: assert (!(mode == 4'h0) ||
                 (ovf_flag == ((op_a[31] == op_b[31]) && (result[31] != op_a[31]))))
            else $error("R3 add overflow mismatch");
        // R6, R7, R8, R9: no flags outside the add/subtract modes
        assert_flags_clear_R6: assert (is_arith || (!carry_flag && !ovf_flag))
            else $error("R6 flags set outside arithmetic modes");
        // R7, R8: compare results only use bit 0
        assert_compare_bit0_R7: assert (!((mode == 4'hA) || (mode == 4'hB)) ||
                                        (result[ALU_W-1:1] == '0))
            else $error("R7 compare upper bits set");
        // R9: unused codes give zero
        assert_unused_zero_R9: assert (!is_unused || (result == '0))
            else $error("R9 unused mode result not zero");
    end

endmodule

bind int_alu32 int_alu32_checker u_int_alu32_checker (
    .op_a       (op_a),
    .op_b       (op_b),
    .mode       (mode),
    .result     (result),
    .carry_flag (carry_flag),
    .ovf_flag   (ovf_flag)
);

// File: tb/int_alu32_bench.sv
// Scoreboard bench for int_alu32: a driver task applies operands on the
// rising edge and queues expected values; a monitor pops and compares them
// on the falling edge.
module int_alu32_bench;

    logic        clk;
    logic        rst_n;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [3:0]  mode;
    logic [31:0] result;
    logic        carry_flag;
    logic        ovf_flag;

    typedef struct {
        logic [31:0] r;
        logic        c;
        logic        v;
        string       rtag;
        string       vtag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    int_alu32 u_int_alu32 (
        .op_a       (op_a),
        .op_b       (op_b),
        .mode       (mode),
        .result     (result),
        .carry_flag (carry_flag),
        .ovf_flag   (ovf_flag)
    );

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Independent reference model from the requirements.
    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input logic [3:0] m);
        exp_t        e;
        logic [32:0] s;
        e.r = '0; e.c = 1'b0; e.v = 1'b0; e.rtag = "R9"; e.vtag = "R9";
        case (m)
            4'h0, 4'h1: begin
                s = {1'b0, a} + {1'b0, b};
                e.r = s[31:0]; e.c = s[32];
                e.v = (m == 4'h0) && (a[31] == b[31]) && (s[31] != a[31]);
                e.rtag = "R1"; e.vtag = (m == 4'h0) ? "R3" : "R4";
            end
            4'h2, 4'h3: begin
                s = {1'b0, a} + {1'b0, ~b} + 33'd1;
                e.r = s[31:0]; e.c = s[32];
                e.v = (m == 4'h2) && (a[31] != b[31]) && (s[31] != a[31]);
                e.rtag = "R2"; e.vtag = (m == 4'h2) ? "R3" : "R4";
            end
            4'h4: begin e.r = a & b;    e.rtag = "R6"; e.vtag = "R6"; end
            4'h5: begin e.r = a | b;    e.rtag = "R6"; e.vtag = "R6"; end
            4'h6: begin e.r = a ^ b;    e.rtag = "R6"; e.vtag = "R6"; end
            4'h7: begin e.r = ~(a | b); e.rtag = "R6"; e.vtag = "R6"; end
            4'hA: begin e.r = {31'd0, ($signed(a) < $signed(b))}; e.rtag = "R7"; e.vtag = "R7"; end
            4'hB: begin e.r = {31'd0, (a < b)}; e.rtag = "R8"; e.vtag = "R8"; end
            default: ;
        endcase
        return e;
    endfunction

    // Driver: apply one operation and queue its expected outputs.
    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] m, input string vtag_override);
        exp_t e;
        @(posedge clk);
        op_a = a; op_b = b; mode = m;
        e = model(a, b, m);
        if (vtag_override != "") e.vtag = vtag_override;
        exp_q.push_back(e);
    endtask

    // Monitor: compare the oldest expectation against the outputs.
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks += 3;
            if (result !== e.r) begin
                n_fail++;
                $display("FAIL %s result: got %h expected %h", e.rtag, result, e.r);
            end
            if (carry_flag !== e.c) begin
                n_fail++;
                $display("FAIL %s carry: got %b expected %b", e.rtag, carry_flag, e.c);
            end
            if (ovf_flag !== e.v) begin
                n_fail++;
                $display("FAIL %s overflow: got %b expected %b", e.vtag, ovf_flag, e.v);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        logic [31:0] seed;
        rst_n = 1'b0; op_a = '0; op_b = '0; mode = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: zero operands in mode 0 give all-zero outputs (R1).
        apply(32'h0, 32'h0, 4'h0, "");
        // R1 add, carry out of bit 31.
        apply(32'd1234, 32'd4321, 4'h0, "");
        apply(32'hFFFF_FFFF, 32'h1, 4'h1, "");
        // R3 / R4 overflow on add.
        apply(32'h7FFF_FFFF, 32'h1, 4'h0, "R3");
        apply(32'h7FFF_FFFF, 32'h1, 4'h1, "R4");
        apply(32'h8000_0000, 32'h8000_0000, 4'h0, "R3");
        apply(32'h8000_0000, 32'h8000_0000, 4'h1, "R4");
        // R2 subtract, no-borrow carry.
        apply(32'd5, 32'd3, 4'h3, "");
        apply(32'd3, 32'd5, 4'h3, "");
        apply(32'd7, 32'd7, 4'h2, "");
        apply(32'h8000_0000, 32'h1, 4'h2, "R3");
        apply(32'h8000_0000, 32'h1, 4'h3, "R4");
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'h2, "R3");
        // R5 no-overflow sign combinations.
        apply(32'h7FFF_FFFF, 32'h8000_0000, 4'h0, "R5");
        apply(32'hFFFF_FFFF, 32'h7FFF_FFFF, 4'h0, "R5");
        apply(32'h8000_0000, 32'h8000_0001, 4'h2, "R5");
        apply(32'h7FFF_FFFF, 32'h0000_0000, 4'h2, "R5");
        // R6 bitwise.
        apply(32'hF0F0_A5A5, 32'hFF00_3C3C, 4'h4, "");
        apply(32'hF0F0_A5A5, 32'hFF00_3C3C, 4'h5, "");
        apply(32'hF0F0_A5A5, 32'hFF00_3C3C, 4'h6, "");
        apply(32'hF0F0_A5A5, 32'hFF00_3C3C, 4'h7, "");
        apply(32'h0, 32'h0, 4'h7, "");
        // R7 signed compare, including overflowing differences.
        apply(32'hFFFF_FFFF, 32'h1, 4'hA, "");
        apply(32'h8000_0000, 32'h7FFF_FFFF, 4'hA, "");
        apply(32'h7FFF_FFFF, 32'h8000_0000, 4'hA, "");
        apply(32'h1234_5678, 32'h1234_5678, 4'hA, "");
        // R8 unsigned compare.
        apply(32'h1, 32'hFFFF_FFFF, 4'hB, "");
        apply(32'hFFFF_FFFF, 32'h1, 4'hB, "");
        apply(32'hCAFE_0000, 32'hCAFE_0000, 4'hB, "");
        // R9 unused codes with nonzero operands.
        for (int m = 8; m < 16; m++) begin
            if (m != 10 && m != 11) apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, m[3:0], "");
        end
        // Pseudo-random sweep across every code.
        seed = 32'h1357_9BDF;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            ra = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            rb = (i % 7 == 0) ? ra : seed;
            apply(ra, rb, i[3:0], "");
        end
        // Drain the queue.
        @(posedge clk);
        @(posedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule